// File: doc/BRIEF.md
# SPI EEPROM word writer

This block programs one 16-bit word into a serial EEPROM that sits behind a four-wire SPI link: chip select, serial clock and data out. A requester presents a word offset and a data word for one cycle. The block checks the offset against the device capacity given on a configuration input. It then takes ownership of the device, confirms that the device is ready, and sends two framed transfers. The first is a write-enable command. The second carries the write command, the byte address and the data. After the second transfer it waits out a fixed programming time. It then drops ownership and pulses `done`. If the request is rejected, `err` pulses instead.

The address field is 8 or 16 bits wide, chosen by a parameter. Parts with 8 address bits reach a ninth address bit through a flag in the command byte. The serial clock half-period and the programming time are both cycle counts set by parameters.

Top module: `eeprom_word_writer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, and `spi_sck`, `busy`, `done`, `err` and `bus_own` are all 0.
- R2: A request whose offset is greater than or equal to `cfg_words` ends with one `err` pulse. `bus_own` never rises and `spi_cs_n` never goes low.
- R3: If `dev_ready` is low in the cycle after `bus_own` rises, `bus_own` falls together with a single `err` pulse, and `spi_cs_n` never goes low.
- R4: An accepted request first sends one frame of exactly 8 bits with value 0x06 (write enable). Chip select then returns high.
- R5: The second frame starts with the 8-bit write command 0x02. When ADDR_W is 8 and the offset is 128 or more, 0x08 is ORed into it. The frame is 8+ADDR_W+16 bits long.
- R6: After the command, the frame carries the offset times two, truncated to ADDR_W bits, MSB first.
- R7: The frame ends with 16 data bits. The low data byte goes first, then the high byte, each MSB first.
- R8: `spi_mosi` only changes while `spi_sck` is low. Every high phase of `spi_sck` lasts HALF_CYC cycles. `spi_sck` is low whenever `spi_cs_n` is high.
- R9: `done` pulses exactly PROG_CYC cycles after chip select rises at the end of the second frame. `bus_own` stays high until the cycle before `done`.
- R10: `busy` is high from the cycle after acceptance through the single-cycle `done` or `err` pulse, and low one cycle later. `done` and `err` are never high together.
- R11: A `req_valid` pulse while `busy` is high does not change the transfer in progress, and it does not start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_offset | input | OFS_W | Word offset to write |
| req_data | input | 16 | Word to write |
| cfg_words | input | OFS_W+1 | Device capacity in words |
| dev_ready | input | 1 | Device ready, sampled once after ownership is taken |
| bus_own | output | 1 | Block owns the device |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when the write succeeds |
| err | output | 1 | One-cycle pulse when the request is rejected |

## Verification
Two instances run side by side, one with 8-bit and one with 16-bit addressing, and both receive the same requests. Directed offsets of 127, 128 and 255 show whether the high-address flag is set only on the 8-bit part. Offsets equal to the capacity and one below it, plus a zero capacity, test the range check at its edge. Random offsets, data and capacities, together with a low ready input, mix successful writes with both kinds of rejection. A second request strobe during a transfer shows whether the latched request is ever overwritten.

// File: rtl/eww_pkg.sv
package eww_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_RANGE, S_ACQ, S_GAP1, S_WREN,
      S_GAP2, S_WRITE, S_PROG, S_DONE, S_FAIL
   } eww_state_e;

   localparam logic [7:0] OPC_WREN   = 8'h06;
   localparam logic [7:0] OPC_WRITE  = 8'h02;
   localparam logic [7:0] OPC_HIADDR = 8'h08;
endpackage

// File: rtl/eww_downcnt.sv
module eww_downcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/eww_shifter.sv
module eww_shifter #(
   parameter int MAXB     = 32,
   parameter int HALF_CYC = 4,
   localparam int LW = $clog2(MAXB + 1),
   localparam int CW = $clog2(HALF_CYC + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [LW-1:0]   len,
   input  logic [MAXB-1:0] vec,
   output logic            cs_n,
   output logic            sck,
   output logic            mosi,
   output logic            fin
);
   logic            active, phase, tick;
   logic [LW-1:0]   left;
   logic [MAXB-1:0] sreg;

   // half-period timer, restarted at frame start and at every phase change
   eww_downcnt #(.W(CW)) i_half (
      .clk  (clk),
      .rst_n(rst_n),
      .load (start | (active & tick)),
      .val  (CW'(HALF_CYC - 1)),
      .zero (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= 1'b0;
         left   <= '0;
         sreg   <= '0;
      end else if (start) begin
         active <= 1'b1;
         phase  <= 1'b0;
         left   <= len;
         sreg   <= vec;
      end else if (active && tick) begin
         if (!phase) begin
            phase <= 1'b1;
         end else begin
            phase <= 1'b0;
            sreg  <= sreg << 1;
            left  <= left - 1'b1;
            if (left == LW'(1)) active <= 1'b0;
         end
      end
   end

   assign cs_n = ~active;
   assign sck  = active & phase;
   assign mosi = active & sreg[MAXB-1];
   assign fin  = active & tick & phase & (left == LW'(1));
endmodule

// File: rtl/eeprom_word_writer.sv
module eeprom_word_writer
   import eww_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFS_W    = 16,
   parameter int HALF_CYC = 4,
   parameter int PROG_CYC = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [OFS_W-1:0] req_offset,
   input  logic [15:0]      req_data,
   input  logic [OFS_W:0]   cfg_words,
   input  logic             dev_ready,
   output logic             bus_own,
   output logic             spi_cs_n,
   output logic             spi_sck,
   output logic             spi_mosi,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int FRAME_W = 8 + ADDR_W + 16;
   localparam int LW      = $clog2(FRAME_W + 1);
   localparam int TMAX    = (PROG_CYC > HALF_CYC) ? PROG_CYC : HALF_CYC;
   localparam int TW      = $clog2(TMAX + 1);

   if (!(ADDR_W == 8 || ADDR_W == 16)) begin : g_bad_aw
      $error("ADDR_W must be 8 or 16");
   end
   if (OFS_W < ADDR_W) begin : g_bad_ofs
      $error("OFS_W must not be narrower than ADDR_W");
   end
   if (HALF_CYC < 1 || PROG_CYC < 1) begin : g_bad_cyc
      $error("HALF_CYC and PROG_CYC must be at least 1");
   end

   eww_state_e       state, nxt;
   logic [OFS_W-1:0] off_q;
   logic [15:0]      data_q;
   logic             t_load, t_zero, sh_start, sh_fin;
   logic [TW-1:0]    t_val;
   logic [7:0]       wr_opc;
   logic [ADDR_W-1:0] addr;
   logic [FRAME_W-1:0] sh_vec;
   logic [LW-1:0]    sh_len;

   // command byte: 8-bit parts carry the ninth address bit in the opcode
   if (ADDR_W == 8) begin : g_a8
      assign wr_opc = OPC_WRITE | ((|off_q[OFS_W-1:7]) ? OPC_HIADDR : 8'h00);
   end else begin : g_a16
      assign wr_opc = OPC_WRITE;
   end

   assign addr   = {off_q[ADDR_W-2:0], 1'b0};
   assign sh_vec = (state == S_GAP1) ? {OPC_WREN, {(FRAME_W-8){1'b0}}}
                                     : {wr_opc, addr, data_q[7:0], data_q[15:8]};
   assign sh_len = (state == S_GAP1) ? LW'(8) : LW'(FRAME_W);
   assign sh_start = ((state == S_GAP1) || (state == S_GAP2)) && t_zero;

   eww_downcnt #(.W(TW)) i_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (t_load),
      .val  (t_val),
      .zero (t_zero)
   );

   eww_shifter #(.MAXB(FRAME_W), .HALF_CYC(HALF_CYC)) i_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .start(sh_start),
      .len  (sh_len),
      .vec  (sh_vec),
      .cs_n (spi_cs_n),
      .sck  (spi_sck),
      .mosi (spi_mosi),
      .fin  (sh_fin)
   );

   always_comb begin
      nxt    = state;
      t_load = 1'b0;
      t_val  = TW'(HALF_CYC - 1);
      unique case (state)
         S_IDLE:  if (req_valid) nxt = S_RANGE;
         S_RANGE: nxt = ({1'b0, off_q} < cfg_words) ? S_ACQ : S_FAIL;
         S_ACQ:   if (dev_ready) begin
                     nxt    = S_GAP1;
                     t_load = 1'b1;
                  end else begin
                     nxt = S_FAIL;
                  end
         S_GAP1:  if (t_zero) nxt = S_WREN;
         S_WREN:  if (sh_fin) begin
                     nxt    = S_GAP2;
                     t_load = 1'b1;
                  end
         S_GAP2:  if (t_zero) nxt = S_WRITE;
         S_WRITE: if (sh_fin) begin
                     nxt    = S_PROG;
                     t_load = 1'b1;
                     t_val  = TW'(PROG_CYC - 1);
                  end
         S_PROG:  if (t_zero) nxt = S_DONE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         off_q  <= '0;
         data_q <= '0;
      end else begin
         state <= nxt;
         if (state == S_IDLE && req_valid) begin
            off_q  <= req_offset;
            data_q <= req_data;
         end
      end
   end

   assign busy    = (state != S_IDLE);
   assign done    = (state == S_DONE);
   assign err     = (state == S_FAIL);
   assign bus_own = (state == S_ACQ)  || (state == S_GAP1) || (state == S_WREN) ||
                    (state == S_GAP2) || (state == S_WRITE) || (state == S_PROG);
endmodule

// File: rtl/eww_check.sv
module eww_check (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic err,
   input logic bus_own,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_mosi
);
   assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
   assert_busy_covers_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> busy);
   assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done || err));
   assert_pulse_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_pulse_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
   assert_cs_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> bus_own);
   assert_mosi_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck) |-> $stable(spi_mosi));
   assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   assert_done_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(bus_own) && !bus_own));
endmodule

bind eeprom_word_writer eww_check i_eww_check (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .bus_own (bus_own),
   .spi_cs_n(spi_cs_n),
   .spi_sck (spi_sck),
   .spi_mosi(spi_mosi)
);

// File: tb/test_eeprom_word_writer.sv
module spi_snoop #(
   parameter int HALF = 2
) (
   input  logic        clk,
   input  logic        clr,
   input  logic        cs_n,
   input  logic        sck,
   input  logic        mosi,
   input  int          cyc,
   output int          nfr,
   output logic [63:0] f0,
   output logic [63:0] f1,
   output int          l0,
   output int          l1,
   output int          rise_cyc,
   output int          werr
);
   logic        psck, pcs;
   logic [63:0] cur;
   int          nb, hiw;

   always @(negedge clk) begin
      if (clr) begin
         nfr <= 0; f0 <= '0; f1 <= '0; l0 <= 0; l1 <= 0;
         rise_cyc <= 0; werr <= 0; cur <= '0; nb <= 0; hiw <= 0;
      end else begin
         if (!psck && sck && !cs_n) begin
            cur <= {cur[62:0], mosi};
            nb  <= nb + 1;
         end
         if (sck) hiw <= hiw + 1;
         else if (psck) begin
            if (hiw != HALF) werr <= werr + 1;
            hiw <= 0;
         end
         if (!pcs && cs_n) begin
            if (nfr == 0) begin f0 <= cur; l0 <= nb; end
            else if (nfr == 1) begin f1 <= cur; l1 <= nb; end
            nfr <= nfr + 1;
            cur <= '0;
            nb  <= 0;
            rise_cyc <= cyc;
         end
      end
      psck <= sck;
      pcs  <= cs_n;
   end
endmodule

module test_eeprom_word_writer;
   localparam int HALF = 2;
   localparam int PROG = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b1;
   logic        req_valid = 1'b0;
   logic [15:0] req_offset = '0;
   logic [15:0] req_data = '0;
   logic [16:0] cfg_words = '0;
   logic        dev_ready = 1'b0;
   int          cyc = 0;
   int          vectors = 0;
   int          fails = 0;

   logic own_a, cs_a, sck_a, mosi_a, busy_a, done_a, err_a;
   logic own_b, cs_b, sck_b, mosi_b, busy_b, done_b, err_b;
   int nfr_a, l0_a, l1_a, rise_a, werr_a;
   int nfr_b, l0_b, l1_b, rise_b, werr_b;
   logic [63:0] f0_a, f1_a, f0_b, f1_b;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   eeprom_word_writer #(.ADDR_W(8), .OFS_W(16), .HALF_CYC(HALF), .PROG_CYC(PROG)) i_eeprom_word_writer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .req_data(req_data), .cfg_words(cfg_words), .dev_ready(dev_ready),
      .bus_own(own_a), .spi_cs_n(cs_a), .spi_sck(sck_a), .spi_mosi(mosi_a),
      .busy(busy_a), .done(done_a), .err(err_a));

   eeprom_word_writer #(.ADDR_W(16), .OFS_W(16), .HALF_CYC(HALF), .PROG_CYC(PROG)) i_eeprom_word_writer_a16 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .req_data(req_data), .cfg_words(cfg_words), .dev_ready(dev_ready),
      .bus_own(own_b), .spi_cs_n(cs_b), .spi_sck(sck_b), .spi_mosi(mosi_b),
      .busy(busy_b), .done(done_b), .err(err_b));

   spi_snoop #(.HALF(HALF)) i_snoop_a (.clk(clk), .clr(clr), .cs_n(cs_a), .sck(sck_a),
      .mosi(mosi_a), .cyc(cyc), .nfr(nfr_a), .f0(f0_a), .f1(f1_a), .l0(l0_a), .l1(l1_a),
      .rise_cyc(rise_a), .werr(werr_a));
   spi_snoop #(.HALF(HALF)) i_snoop_b (.clk(clk), .clr(clr), .cs_n(cs_b), .sck(sck_b),
      .mosi(mosi_b), .cyc(cyc), .nfr(nfr_b), .f0(f0_b), .f1(f1_b), .l0(l0_b), .l1(l1_b),
      .rise_cyc(rise_b), .werr(werr_b));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_op(input int aw, input int off);
      return 8'h02 | ((aw == 8 && off >= 128) ? 8'h08 : 8'h00);
   endfunction

   function automatic longint exp_frame(input int aw, input int off, input logic [15:0] d);
      longint a;
      a = longint'(off * 2) & ((64'd1 << aw) - 1);
      return (longint'(exp_op(aw, off)) << (16 + aw)) | (a << 16) |
             longint'({d[7:0], d[15:8]});
   endfunction

   task automatic eval(input int aw, input int off, input logic [15:0] d, input int words,
                       input bit rdy, input bit spur, input int nd, input int ne,
                       input bit own, input bit errown, input int dcyc, input int nfr,
                       input logic [63:0] f0, input logic [63:0] f1, input int l0,
                       input int l1, input int rise, input int werr);
      longint ef, mask;
      if (off >= words) begin
         chk(ne == 1 && nd == 0, "R2", "err/done pulses", {nd, ne}, 64'h1);
         chk(nfr == 0, "R2", "frames", nfr, 0);
         chk(!own, "R2", "bus_own seen", own, 0);
      end else if (!rdy) begin
         chk(ne == 1 && nd == 0, "R3", "err/done pulses", {nd, ne}, 64'h1);
         chk(nfr == 0, "R3", "frames", nfr, 0);
         chk(!errown, "R3", "bus_own at err", errown, 0);
      end else begin
         ef   = exp_frame(aw, off, d);
         mask = (64'd1 << (24 + aw)) - 1;
         chk(nd == 1 && ne == 0, "R10", "done/err pulses", {nd, ne}, 64'h100000000);
         chk(nfr == 2, "R4", "frames", nfr, 2);
         chk(l0 == 8 && f0[7:0] == 8'h06, "R4", "wren frame", {l0, f0[7:0]}, {8, 8'h06});
         chk(l1 == 24 + aw, "R5", "write frame length", l1, 24 + aw);
         chk(((f1 >> (16 + aw)) & 64'hff) == (ef >> (16 + aw)), "R5", "opcode",
             (f1 >> (16 + aw)) & 64'hff, ef >> (16 + aw));
         chk(((f1 >> 16) & ((64'd1 << aw) - 1)) == ((ef >> 16) & ((64'd1 << aw) - 1)),
             "R6", "address", (f1 >> 16) & ((64'd1 << aw) - 1), (ef >> 16) & ((64'd1 << aw) - 1));
         chk(f1[15:0] == ef[15:0], "R7", "data", f1[15:0], ef[15:0]);
         chk(werr == 0, "R8", "sck high width errors", werr, 0);
         chk(dcyc - rise == PROG, "R9", "prog delay", dcyc - rise, PROG);
         if (spur) chk((f1 & mask) == ef && nd == 1, "R11", "frame after stray request",
                       f1 & mask, ef);
      end
   endtask

   task automatic run_txn(input int off, input logic [15:0] d, input int words,
                          input bit rdy, input bit spur);
      int nd_a = 0, ne_a = 0, nd_b = 0, ne_b = 0, dc_a = 0, dc_b = 0;
      bit fin_a = 0, fin_b = 0, ow_a = 0, ow_b = 0, eo_a = 0, eo_b = 0;
      @(negedge clk);
      clr = 1'b1; cfg_words = 17'(words); dev_ready = rdy;
      @(negedge clk);
      clr = 1'b0; req_offset = 16'(off); req_data = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy_a && busy_b, "R10", "busy after accept", {busy_a, busy_b}, 2'b11);
      for (int i = 0; i < 4000 && !(fin_a && fin_b); i++) begin
         if (own_a) ow_a = 1;
         if (own_b) ow_b = 1;
         if (done_a) begin nd_a++; dc_a = cyc; fin_a = 1; end
         if (done_b) begin nd_b++; dc_b = cyc; fin_b = 1; end
         if (err_a) begin ne_a++; eo_a = own_a; fin_a = 1; end
         if (err_b) begin ne_b++; eo_b = own_b; fin_b = 1; end
         if (spur && i == 3) begin
            req_valid = 1'b1; req_offset = 16'(off) ^ 16'h0005; req_data = ~d;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(!busy_a && !busy_b, "R10", "busy after finish", {busy_a, busy_b}, 0);
      @(negedge clk);
      eval(8, off, d, words, rdy, spur, nd_a, ne_a, ow_a, eo_a, dc_a, nfr_a, f0_a, f1_a,
           l0_a, l1_a, rise_a, werr_a);
      eval(16, off, d, words, rdy, spur, nd_b, ne_b, ow_b, eo_b, dc_b, nfr_b, f0_b, f1_b,
           l0_b, l1_b, rise_b, werr_b);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int w;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cs_a && cs_b && !sck_a && !sck_b, "R1", "serial idle", {cs_a, cs_b, sck_a, sck_b}, 4'b1100);
      chk(!busy_a && !done_a && !err_a && !own_a, "R1", "status a", {busy_a, done_a, err_a, own_a}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_b && !done_b && !err_b && !own_b, "R1", "status b", {busy_b, done_b, err_b, own_b}, 0);
      // directed corners
      run_txn(5, 16'h1234, 256, 1, 0);
      run_txn(127, 16'hA55A, 256, 1, 0);   // R5 below flag threshold
      run_txn(128, 16'h00FF, 256, 1, 0);   // R5 flag set on 8-bit part
      run_txn(255, 16'hFF00, 256, 1, 0);
      run_txn(256, 16'hBEEF, 256, 1, 0);   // R2 offset equals capacity
      run_txn(0, 16'hCAFE, 1, 1, 0);
      run_txn(1, 16'hCAFE, 1, 1, 0);       // R2 one past single word
      run_txn(0, 16'h0001, 0, 1, 0);       // R2 zero capacity
      run_txn(40, 16'h7E81, 100, 0, 0);    // R3 not ready
      run_txn(200, 16'h8421, 256, 1, 1);   // R11 stray request
      for (int n = 0; n < 30; n++) begin
         w = 1 + int'($urandom % 256);
         run_txn(int'($urandom % (w + 8)), 16'($urandom), w, ($urandom % 5) != 0,
                 ($urandom % 4) == 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule